// File: doc/BRIEF.md
# Mode-Configurable Bit-Wide LUT RAM

This block is a small bit-wide memory of the kind built from the lookup tables of a logic cell. It holds two banks of single-bit locations and lets a static mode input arrange them four ways: one 16x1 single-port array, two independent 16x1 single-port arrays, one 32x1 single-port array, or a 16x1 array with a second read-only port. Writes are taken on the rising edge of the write clock. Reads are combinational, so each output follows its address with no clock delay.

The mode input is meant to be tied off or changed only while no write is pending. Bank 0 is the same storage in every mode, so its contents carry over when the mode changes. The bank depth comes from the address-width parameter, and the reset contents come from an initial-value parameter.

Top module: `lut_ram_cfg`

## Requirements
- R1: While `rst_n` is low, every location takes its bit from `INIT`, which defaults to all zeros. Bit i of `INIT` maps to bank 0 location i when i < 16, and to bank 1 location i-16 otherwise.
- R2: With `cfg_mode` = 0 (single 16x1), a rising edge of `clk_w` with `we` high stores `din0` in bank 0 at `addr_a`. `dout0` shows bank 0 at `addr_a`.
- R3: With `cfg_mode` = 1 (paired 16x1), bank 0 uses `addr_a`, `din0` and `dout0`, and bank 1 uses `addr_b`, `din1` and `dout1`. One `we` edge writes both banks.
- R4: With `cfg_mode` = 2 (32x1), the 5-bit address is {`din1`, `addr_a`}, with `din1` as the most significant bit. `din0` is the write data and `dout0` is the read data. Only the addressed location changes.
- R5: With `cfg_mode` = 3 (dual-port 16x1), writes go to bank 0 at `addr_a`. `dout0` reads bank 0 at `addr_a` and `dout1` reads bank 0 at `addr_b`.
- R6: In dual-port mode, when `addr_b` equals the address being written, `dout1` shows the old bit before the write edge and the new bit after it.
- R7: When `we` is low at a clock edge, no location in either bank changes.
- R8: A change of address alone changes the data outputs within the same cycle, with no clock edge.
- R9: `dout1` is driven to 0 in single 16x1 mode and in 32x1 mode.
- R10: Bank 0 is the array seen at `addr_a` in modes 0, 1 and 3, and it is the lower half (locations 0-15) in 32x1 mode. Its contents survive a mode change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; loads `INIT` |
| cfg_mode | input | 2 | Organisation: 0 single 16x1, 1 paired 16x1, 2 32x1, 3 dual-port 16x1 |
| we | input | 1 | Write enable, shared by both banks |
| din0 | input | 1 | Write data (bank 0, or the 32x1 array) |
| din1 | input | 1 | Bank 1 write data in paired mode; top address bit in 32x1 mode |
| addr_a | input | ADDR_W | Write/read address of the first port |
| addr_b | input | ADDR_W | Bank 1 address in paired mode; read-only address in dual-port mode |
| dout0 | output | 1 | Combinational read data of the first port |
| dout1 | output | 1 | Bank 1 data, second-port data, or 0 |

## Verification
The bench pushes `din1` to both values in 32x1 mode. If the design treated `din1` as data instead of the top address bit, a write meant for the upper half would land in bank 0, and a later sweep in 16x1 mode would show it. The bench also aims the read-only port at the location being written in dual-port mode: a registered read would show the old bit after the edge, and a write-through path would show the new bit before it. Random writes with `we` low, followed by full sweeps, show any write that leaks through. Paired-mode writes show whether one bank was missed, whether the wrong address bus was used, or whether `dout1` leaked a bank value in a mode that must hold it at zero.

// File: rtl/lut_ram_pkg.sv
package lut_ram_pkg;

   typedef enum logic [1:0] {
      MODE_NARROW = 2'd0,
      MODE_PAIR   = 2'd1,
      MODE_WIDE   = 2'd2,
      MODE_DUAL   = 2'd3
   } ram_mode_e;

   localparam int NBANK = 2;

   typedef struct packed {
      logic en;
      logic dat;
   } wr_ctl_t;

   function automatic logic mode_drives_dout1(ram_mode_e m);
      return (m == MODE_PAIR) || (m == MODE_DUAL);
   endfunction

endpackage

// File: rtl/lut_ram_bank.sv
module lut_ram_bank
   import lut_ram_pkg::*;
#(
   parameter int AW = 4,
   parameter int DEPTH = 2 ** AW,
   parameter logic [DEPTH-1:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wr_ctl_t       wr,
   input  logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] rd_addr_x,
   input  logic [AW-1:0] rd_addr_y,
   output logic          rd_x,
   output logic          rd_y
);

   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= INIT;
      end else if (wr.en) begin
         cells[wr_addr] <= wr.dat;
      end
   end

   assign rd_x = cells[rd_addr_x];
   assign rd_y = cells[rd_addr_y];

   // R7: no enable, no change anywhere in the bank
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr.en |=> $stable(cells));

   // R2: an enabled write lands at the captured address
   assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr.en |=> cells[$past(wr_addr)] == $past(wr.dat));

   // R4: a write never touches more than one location
   assert_one_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr.en |=> $countones(cells ^ $past(cells)) <= 1);

endmodule

// File: rtl/lut_ram_route.sv
module lut_ram_route
   import lut_ram_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  ram_mode_e                  mode,
   input  logic                       we,
   input  logic                       din0,
   input  logic                       din1,
   input  logic [AW-1:0]              addr_a,
   input  logic [AW-1:0]              addr_b,
   output wr_ctl_t [NBANK-1:0]        wr,
   output logic [NBANK-1:0][AW-1:0]   waddr
);

   always_comb begin
      wr       = '0;
      waddr[0] = addr_a;
      waddr[1] = (mode == MODE_PAIR) ? addr_b : addr_a;
      unique case (mode)
         MODE_NARROW, MODE_DUAL: begin
            wr[0] = '{en: we, dat: din0};
         end
         MODE_PAIR: begin
            wr[0] = '{en: we, dat: din0};
            wr[1] = '{en: we, dat: din1};
         end
         MODE_WIDE: begin
            wr[0] = '{en: we & ~din1, dat: din0};
            wr[1] = '{en: we &  din1, dat: din0};
         end
         default: wr = '0;
      endcase
   end

   // R3: paired mode shares one enable across both banks
   assert_shared_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PAIR) |-> (wr[0].en == we) && (wr[1].en == we));

   // R4: 32x1 mode enables at most one bank, picked by din1
   assert_wide_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WIDE) |-> $countones({wr[1].en, wr[0].en}) <= 1);

   // R5: single and dual-port modes leave bank 1 alone
   assert_bank1_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_NARROW || mode == MODE_DUAL) |-> !wr[1].en);

endmodule

// File: rtl/lut_ram_outmux.sv
module lut_ram_outmux
   import lut_ram_pkg::*;
(
   input  ram_mode_e         mode,
   input  logic              sel_hi,
   input  logic [NBANK-1:0]  bank_x,
   input  logic [NBANK-1:0]  bank_y,
   output logic              dout0,
   output logic              dout1
);

   always_comb begin
      dout0 = (mode == MODE_WIDE) ? bank_x[sel_hi] : bank_x[0];
      unique case (mode)
         MODE_PAIR: dout1 = bank_y[1];
         MODE_DUAL: dout1 = bank_y[0];
         default:   dout1 = 1'b0;
      endcase
   end

endmodule

// File: rtl/lut_ram_cfg.sv
module lut_ram_cfg
   import lut_ram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter logic [NBANK*(2**ADDR_W)-1:0] INIT = '0
) (
   input  logic              clk_w,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              we,
   input  logic              din0,
   input  logic              din1,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic              dout0,
   output logic              dout1
);

   localparam int DEPTH = 2 ** ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_aw
      $error("lut_ram_cfg: ADDR_W must lie in 1..8");
   end

   ram_mode_e                       mode;
   wr_ctl_t [NBANK-1:0]             wr;
   logic [NBANK-1:0][ADDR_W-1:0]    waddr;
   logic [NBANK-1:0]                bank_x;
   logic [NBANK-1:0]                bank_y;

   assign mode = ram_mode_e'(cfg_mode);

   lut_ram_route #(.AW(ADDR_W)) u_route (
      .clk    (clk_w),
      .rst_n  (rst_n),
      .mode   (mode),
      .we     (we),
      .din0   (din0),
      .din1   (din1),
      .addr_a (addr_a),
      .addr_b (addr_b),
      .wr     (wr),
      .waddr  (waddr)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      lut_ram_bank #(
         .AW    (ADDR_W),
         .DEPTH (DEPTH),
         .INIT  (INIT[b*DEPTH +: DEPTH])
      ) u_bank (
         .clk       (clk_w),
         .rst_n     (rst_n),
         .wr        (wr[b]),
         .wr_addr   (waddr[b]),
         .rd_addr_x (addr_a),
         .rd_addr_y (addr_b),
         .rd_x      (bank_x[b]),
         .rd_y      (bank_y[b])
      );
   end

   lut_ram_outmux u_out (
      .mode   (mode),
      .sel_hi (din1),
      .bank_x (bank_x),
      .bank_y (bank_y),
      .dout0  (dout0),
      .dout1  (dout1)
   );

   // R9: the second output is quiet when the mode has no second port
   assert_unused_zero_R9: assert property (@(posedge clk_w) disable iff (!rst_n)
      !mode_drives_dout1(mode) |-> (dout1 == 1'b0));

   // R6: the read-only port sees fresh data one edge after a matching write
   assert_dual_fresh_R6: assert property (@(posedge clk_w) disable iff (!rst_n)
      (mode == MODE_DUAL && we) |=>
         (!(mode == MODE_DUAL && addr_b == $past(addr_a)) || dout1 == $past(din0)));

endmodule

// File: tb/lut_ram_cfg_test.sv
module lut_ram_cfg_test;

   logic       clk_w = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic       we = 1'b0;
   logic       din0 = 1'b0;
   logic       din1 = 1'b0;
   logic [3:0] addr_a = '0;
   logic [3:0] addr_b = '0;
   logic       dout0;
   logic       dout1;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] mdl = '0;

   always #5 clk_w = ~clk_w;

   lut_ram_cfg uut (
      .clk_w(clk_w), .rst_n(rst_n), .cfg_mode(cfg_mode), .we(we),
      .din0(din0), .din1(din1), .addr_a(addr_a), .addr_b(addr_b),
      .dout0(dout0), .dout1(dout1)
   );

   function automatic logic exp0(logic [1:0] m, logic [3:0] aa, logic d1);
      return (m == 2'd2) ? mdl[{d1, aa}] : mdl[{1'b0, aa}];
   endfunction

   function automatic logic exp1(logic [1:0] m, logic [3:0] ab);
      if (m == 2'd1) return mdl[{1'b1, ab}];
      if (m == 2'd3) return mdl[{1'b0, ab}];
      return 1'b0;
   endfunction

   function automatic string tag0(logic [1:0] m);
      case (m)
         2'd0: return "R2";
         2'd1: return "R3";
         2'd2: return "R4";
         default: return "R5";
      endcase
   endfunction

   function automatic string tag1(logic [1:0] m);
      case (m)
         2'd1: return "R3";
         2'd3: return "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic model_write(logic [1:0] m, logic d0, logic d1,
                              logic [3:0] aa, logic [3:0] ab);
      case (m)
         2'd1: begin
            mdl[{1'b0, aa}] = d0;
            mdl[{1'b1, ab}] = d1;
         end
         2'd2: mdl[{d1, aa}] = d0;
         default: mdl[{1'b0, aa}] = d0;
      endcase
   endtask

   // drive at the falling edge, check the read before and after the write edge
   task automatic step(logic [1:0] m, logic w, logic d0, logic d1,
                       logic [3:0] aa, logic [3:0] ab);
      @(negedge clk_w);
      cfg_mode = m; we = w; din0 = d0; din1 = d1; addr_a = aa; addr_b = ab;
      #1;
      chk(tag0(m), dout0, exp0(m, aa, d1));
      chk((m == 2'd3 && aa == ab && w) ? "R6" : tag1(m), dout1, exp1(m, ab));
      @(posedge clk_w);
      #1;
      if (w) model_write(m, d0, d1, aa, ab);
      chk(w ? tag0(m) : "R7", dout0, exp0(m, aa, d1));
      chk((m == 2'd3 && aa == ab && w) ? "R6" : tag1(m), dout1, exp1(m, ab));
   endtask

   // read all 32 locations through 32x1 mode with writes off
   task automatic sweep(string req);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk_w);
         cfg_mode = 2'd2; we = 1'b0; din1 = i[4]; addr_a = i[3:0];
         #1;
         chk(req, dout0, mdl[i]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk_w);
      @(negedge clk_w);
      rst_n = 1'b1;

      // R1: reset contents are all zero
      sweep("R1");

      // R2: directed single-port write and read back
      step(2'd0, 1'b1, 1'b1, 1'b0, 4'd7, 4'd0);
      step(2'd0, 1'b0, 1'b0, 1'b0, 4'd7, 4'd0);

      // R4 / R10: upper-half write must not appear in bank 0
      step(2'd2, 1'b1, 1'b1, 1'b1, 4'd3, 4'd0);
      step(2'd0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd0);
      chk("R10", dout0, 1'b0);
      step(2'd2, 1'b1, 1'b1, 1'b0, 4'd9, 4'd0);
      step(2'd3, 1'b0, 1'b0, 1'b0, 4'd9, 4'd9);
      chk("R10", dout0, 1'b1);

      // R6: dual port, read-only port on the written location
      step(2'd3, 1'b1, 1'b1, 1'b0, 4'd5, 4'd5);
      step(2'd3, 1'b1, 1'b0, 1'b0, 4'd5, 4'd5);

      // R3: paired banks written together at separate addresses
      step(2'd1, 1'b1, 1'b1, 1'b1, 4'd2, 4'd14);
      step(2'd1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd14);

      // R8: address change alone moves the output within the cycle
      @(negedge clk_w);
      cfg_mode = 2'd1; we = 1'b0; addr_a = 4'd2; addr_b = 4'd14;
      #1;
      chk("R8", dout1, mdl[30]);
      addr_b = 4'd13;
      #1;
      chk("R8", dout1, mdl[29]);
      addr_a = 4'd7;
      #1;
      chk("R8", dout0, mdl[7]);

      // random mix across all modes
      for (int n = 0; n < 600; n++) begin
         logic [3:0] ra = 4'($urandom);
         logic [3:0] rb = ($urandom % 4 == 0) ? ra : 4'($urandom);
         step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ra, rb);
      end

      // R7: burst with writes off, then full sweep
      for (int n = 0; n < 60; n++) begin
         step(2'($urandom), 1'b0, 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
      end
      sweep("R7");
      sweep("R10");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule